// File: doc/BRIEF.md
# Decaying Strength Storage Node

This block models a charge-holding node that sits on a net with several drivers. Each driver port carries a 7-bit strength, where 0 is the weakest of 128 levels and 127 the strongest, together with an active flag. The net settles on the largest strength among the active drivers. The node keeps that value once the drivers let go.

While no driver is active, the held strength leaks away. A free-running timer marks the end of each decay period, and every such mark lowers the held value by one until it reaches zero. Driver activity does not restart that timer. The decay period, the driver count and the strength width are parameters, and the period is counted in clock cycles.

Top module: `strength_keeper`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the node strength becomes 0 and the decay timer restarts. With rst_n high from then on and no driver active, the first decrement happens at the DECAY_CYC-th rising edge after release.
- R2: The resolved strength is the largest `drv_str` lane among the lanes whose `drv_act` bit is set. Lane i occupies bits [i*STR_W +: STR_W]. The strength of an inactive lane has no effect on the result.
- R3: At every edge where at least one driver is active, the node loads the resolved strength. A decay tick in the same cycle is ignored.
- R4: At a decay tick with no driver active and a nonzero strength, the node strength drops by exactly 1.
- R5: With no driver active, a node strength of 0 stays at 0 at every edge, ticks included.
- R6: Decay ticks fall on rising edges whose count since reset release is a multiple of DECAY_CYC, whether or not drivers were active before.
- R7: `node_driven` is high in exactly those cycles in which at least one `drv_act` bit is high. It follows the inputs combinationally.
- R8: With no driver active, the node strength does not change at edges that carry no decay tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| drv_str | input | NUM_DRV*STR_W | Packed strength of every driver lane |
| drv_act | input | NUM_DRV | Active flag per driver lane |
| node_str | output | STR_W | Strength currently held on the node |
| node_driven | output | 1 | High while any driver is active |

## Verification
The bench builds the block with three drivers, 7-bit strengths and a decay period of three cycles. The short period lets a full drain from 127 to 0 fit within a few hundred cycles. Every strength value is loaded and then left to decay through several ticks, and all eight active-lane masks are crossed with sixteen strength patterns. A reset in the middle of a run shows that the timer phase restarts, and the strength model in the bench counts edges from release.

// File: rtl/strength_keeper_pkg.sv
// Package: shared constants and helpers for the decaying strength node.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package strength_keeper_pkg;

    // Default width of one drive strength (128 levels).
    localparam int STR_W_DEF = 7;

    // Counter width able to hold 0..n-1, never less than one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/drive_resolver.sv
// Module: drive_resolver
// Combines all driver lanes into one net strength by taking the maximum
// over active lanes. An inactive lane is masked to 0, so an empty set
// resolves to 0. Purely combinational; assumes NUM_DRV >= 1.
module drive_resolver #(
    parameter int NUM_DRV = 4,
    parameter int STR_W   = 7
) (
    input  logic [NUM_DRV*STR_W-1:0] drv_str,
    input  logic [NUM_DRV-1:0]       drv_act,
    output logic [STR_W-1:0]         res_str,
    output logic                     any_act
);

    logic [STR_W-1:0] lane [NUM_DRV];

    // Mask every lane by its active flag.
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_lane
        assign lane[g] = drv_act[g] ? drv_str[g*STR_W +: STR_W] : '0;
    end

    // Reduce the masked lanes to their maximum.
    always_comb begin
        res_str = '0;
        for (int i = 0; i < NUM_DRV; i++) begin
            if (lane[i] > res_str) begin
                res_str = lane[i];
            end
        end
    end

    // Flag that at least one driver is on the net.
    assign any_act = |drv_act;

endmodule

// File: rtl/decay_timer.sv
// Module: decay_timer
// Free-running counter that emits a one-cycle tick every DECAY_CYC
// clocks. Only reset restarts it. Assumes DECAY_CYC >= 1; with 1 the
// tick is high in every cycle.
module decay_timer #(
    parameter int DECAY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    import strength_keeper_pkg::*;

    localparam int CW = cnt_width(DECAY_CYC);
    localparam logic [CW-1:0] LAST = CW'(DECAY_CYC - 1);

    logic [CW-1:0] cnt;

    // Tick on the final count of each period.
    assign tick = (cnt == LAST);

    // Advance the period counter and wrap after the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/strength_keeper.sv
// Module: strength_keeper (top)
// Storage node on a multi-driver net. It follows the maximum active
// strength while driven, and while undriven it loses one step per decay
// tick down to 0. Driving wins over a tick in the same cycle.
// Assumes synchronous inputs and DECAY_CYC >= 1.
module strength_keeper #(
    parameter int NUM_DRV   = 4,
    parameter int STR_W     = strength_keeper_pkg::STR_W_DEF,
    parameter int DECAY_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_DRV*STR_W-1:0] drv_str,
    input  logic [NUM_DRV-1:0]       drv_act,
    output logic [STR_W-1:0]         node_str,
    output logic                     node_driven
);

    logic [STR_W-1:0] res_str;
    logic             any_act;
    logic             decay_tick;
    logic [STR_W-1:0] held;

    drive_resolver #(
        .NUM_DRV (NUM_DRV),
        .STR_W   (STR_W)
    ) u_resolver (
        .drv_str (drv_str),
        .drv_act (drv_act),
        .res_str (res_str),
        .any_act (any_act)
    );

    decay_timer #(
        .DECAY_CYC (DECAY_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (decay_tick)
    );

    // Hold the driven strength, or leak one step per tick when undriven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (any_act) begin
            held <= res_str;
        end else if (decay_tick && (held != '0)) begin
            held <= held - 1'b1;
        end
    end

    assign node_str    = held;
    assign node_driven = any_act;

endmodule

// File: rtl/strength_keeper_chk.sv
// Module: strength_keeper_chk
// Property checker bound to strength_keeper. It observes the ports and
// the resolver and timer outputs, and assumes the same parameters as
// the bound instance.
module strength_keeper_chk #(
    parameter int NUM_DRV = 4,
    parameter int STR_W   = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_DRV*STR_W-1:0] drv_str,
    input logic [NUM_DRV-1:0]       drv_act,
    input logic [STR_W-1:0]         node_str,
    input logic [STR_W-1:0]         res_str,
    input logic                     any_act,
    input logic                     tick
);

    // R1: reset clears the node.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> node_str == '0);

    // R2: resolution is at least every active lane.
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_lane_chk
        assert_res_covers_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            drv_act[g] |-> res_str >= drv_str[g*STR_W +: STR_W]);
    end

    // R3: a driven cycle loads the resolved strength.
    assert_driven_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |=> node_str == $past(res_str));

    // R4: an undriven tick lowers a nonzero node by one.
    assert_tick_decrements_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_act && tick && node_str != '0) |=> node_str == $past(node_str) - STR_W'(1));

    // R5: an undriven zero node stays at zero.
    assert_floor_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_act && node_str == '0) |=> node_str == '0);

    // R8: no change between ticks while undriven.
    assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_act && !tick) |=> $stable(node_str));

endmodule

bind strength_keeper strength_keeper_chk #(
    .NUM_DRV (NUM_DRV),
    .STR_W   (STR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_str  (drv_str),
    .drv_act  (drv_act),
    .node_str (node_str),
    .res_str  (res_str),
    .any_act  (any_act),
    .tick     (decay_tick)
);

// File: tb/strength_keeper_bench.sv
// Bench: drives strength_keeper with 3 drivers, 7-bit strengths and a
// 3-cycle decay period. An arithmetic model counts edges since reset
// release to place the decay ticks.
module strength_keeper_bench;

    localparam int CLK_P = 10;
    localparam int ND    = 3;
    localparam int SW    = 7;
    localparam int DC    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND*SW-1:0] drv_str = '0;
    logic [ND-1:0] drv_act = '0;
    logic [SW-1:0] node_str;
    logic          node_driven;

    int n_chk = 0;
    int n_bad = 0;
    int edge_idx = 0;
    int exp_str = 0;
    bit done = 1'b0;

    strength_keeper #(
        .NUM_DRV   (ND),
        .STR_W     (SW),
        .DECAY_CYC (DC)
    ) u_strength_keeper (
        .clk         (clk),
        .rst_n       (rst_n),
        .drv_str     (drv_str),
        .drv_act     (drv_act),
        .node_str    (node_str),
        .node_driven (node_driven)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, model the rising edge, check.
    task automatic step(input logic [ND-1:0] act, input int a, input int b, input int c);
        int mx;
        string tag;
        drv_act = act;
        drv_str = {SW'(c), SW'(b), SW'(a)};
        #1;
        check("R7 driven flag", int'(node_driven), int'(|act));
        mx = 0;
        if (act[0] && a > mx) mx = a;
        if (act[1] && b > mx) mx = b;
        if (act[2] && c > mx) mx = c;
        @(posedge clk);
        edge_idx++;
        if (|act) begin
            exp_str = mx;
            tag = "R2/R3 driven load";
        end else if (edge_idx % DC == 0) begin
            if (exp_str > 0) begin
                exp_str--;
                tag = "R4/R6 tick decrement";
            end else begin
                tag = "R5 floor at zero";
            end
        end else begin
            tag = "R8 hold between ticks";
        end
        @(negedge clk);
        check(tag, int'(node_str), exp_str);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        drv_act = 3'b111;
        drv_str = {SW'(90), SW'(50), SW'(20)};
        repeat (cycles) @(posedge clk);
        @(negedge clk);
        check("R1 reset clears node", int'(node_str), 0);
        rst_n = 1'b1;
        edge_idx = 0;
        exp_str = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(3);

        // R1/R6: load, reset mid-run, then verify the restarted tick phase.
        step(3'b010, 0, 100, 0);
        step(3'b000, 0, 0, 0);
        do_reset(1);
        step(3'b001, 77, 0, 0);
        for (int k = 0; k < 6; k++) step(3'b000, 0, 0, 0);

        // Every strength loaded on a rotating lane, then left to decay.
        for (int v = 0; v < 128; v++) begin
            step(3'(1 << (v % ND)), v, v, v);
            for (int k = 0; k < 4; k++) step(3'b000, 0, 0, 0);
        end

        // R2: all active masks crossed with strength patterns, inactive
        // lanes carrying large values that must not win.
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 8; m++) begin
                step(3'(m), (p * 8 + 1) % 128, 127 - p * 5, (p * 37 + 11) % 128);
            end
            step(3'b000, 0, 0, 0);
        end

        // R3: steady drive spanning many ticks does not decay.
        for (int k = 0; k < 10; k++) step(3'b100, 0, 0, 40);

        // R4/R5: full drain from the strongest level, then stay at zero.
        step(3'b011, 127, 3, 0);
        for (int k = 0; k < 400; k++) step(3'b000, 0, 0, 0);

        // R3: driving wins over a tick landing in the same cycle.
        for (int k = 0; k < 6; k++) step(3'b001, 60 - k, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule